// File: doc/BRIEF.md
# Coupled-LCG Pseudorandom Bit Generator

This block produces one pseudorandom bit on every clock from four independent linear congruential units that run side by side. Each unit holds a W-bit state. On every clock it replaces that state with `(a*state + b) mod 2^W`. The multiplier `a` is restricted to `2^r + 1`, so the product is formed as a shift and an add. A three-operand adder then sums the shifted state, the state and the increment, and no multiplier is built.

Two magnitude comparators work on the four next-state values. One compares units 0 and 1, and the other compares units 2 and 3. The two results are XORed and registered as the output bit. There is no buffer, no conditional release of bits and no handshake: a consumer takes one bit per clock, starting with the first edge after reset is released.

Each unit's shift amount and increment are fixed when the block is built, as is the width. While reset is held, the seeds are loaded from four input ports. An elaboration check rejects an increment that is even. It also rejects a shift amount below 2 or one that is not smaller than the width. Together these rules give every unit a full period of 2^W.

Top module: `clcg_bitgen`

## Requirements
- R1: While `rst` is high at a rising edge, unit k loads `seed_k` and `bit_out` is 0 after that edge.
- R2: With `rst` low at a rising edge, unit k takes the value `((2^SHk + 1)*s_k + INCk) mod 2^W`, where s_k is that unit's own previous state. As a result, bit 0 of every state toggles on each clock, and the two low bits advance by INCk mod 4.
- R3: The first comparison result is 1 only when unit 0's next value is strictly greater than unit 1's next value. Equal values give 0.
- R4: The second comparison result is 1 only when unit 2's next value is strictly greater than unit 3's next value. Equal values give 0.
- R5: At each rising edge with `rst` low, `bit_out` takes the XOR of the two comparison results formed from that edge's next values. A new bit therefore appears on every clock, and the first one follows the first edge after reset is released.
- R6: With odd increments and shift amounts of at least 2, the output sequence repeats with a period of 2^W clocks, counted from any point after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads the seeds |
| seed0 | input | W | Start value for unit 0 |
| seed1 | input | W | Start value for unit 1 |
| seed2 | input | W | Start value for unit 2 |
| seed3 | input | W | Start value for unit 3 |
| bit_out | output | 1 | Registered pseudorandom bit, one per clock |

## Verification
The bench builds the generator with W = 8, shift amounts 2, 3, 4 and 5, and increments 1, 7, 13 and 201. With a 256-entry state space, the output can be recorded over two whole periods, which makes the 2^W repetition of R6 directly observable. The bench also searches all 256 seeds to find one that forces unit 1's next value to equal unit 0's next value, and another that does the same for units 3 and 2, so the strict-greater ties of R3 and R4 occur on a chosen cycle. Several seed sets, including all-zero and all-ones seeds and a reset asserted mid-run, are then compared bit for bit against a behavioural model.

// File: rtl/clcg_bitgen.sv
module clcg_bitgen #(
  parameter int W    = 32,
  parameter int SH0  = 3,
  parameter int SH1  = 5,
  parameter int SH2  = 7,
  parameter int SH3  = 9,
  parameter int INC0 = 32'h1234_5679,
  parameter int INC1 = 32'h0abc_de01,
  parameter int INC2 = 32'h3141_5927,
  parameter int INC3 = 32'h2718_2819
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed0,
  input  logic [W-1:0] seed1,
  input  logic [W-1:0] seed2,
  input  logic [W-1:0] seed3,
  output logic         bit_out
);

  localparam int NU = 4;
  localparam int SH_A  [NU] = '{SH0, SH1, SH2, SH3};
  localparam int INC_A [NU] = '{INC0, INC1, INC2, INC3};

  logic [W-1:0] seed_v [NU];
  logic [W-1:0] st     [NU];
  logic [W-1:0] nx     [NU];
  logic         b_gt, c_gt;

  assign seed_v[0] = seed0;
  assign seed_v[1] = seed1;
  assign seed_v[2] = seed2;
  assign seed_v[3] = seed3;

  for (genvar k = 0; k < NU; k++) begin : g_unit
    localparam logic [W-1:0] INC_W = W'(INC_A[k]);
    localparam logic [1:0]   INC_L = INC_W[1:0];

    initial begin
      param_chk: assert ((INC_A[k] % 2 != 0) && SH_A[k] >= 2 && SH_A[k] < W)
        else $error("unit %0d: increment must be odd and shift in [2, W-1]", k);
    end

    assign nx[k] = (st[k] << SH_A[k]) + st[k] + INC_W;

    always_ff @(posedge clk) begin
      if (rst) st[k] <= seed_v[k];
      else     st[k] <= nx[k];
    end

    // R1
    seed_load_chk: assert property (@(posedge clk) rst |=> (st[k] == $past(seed_v[k])));
    // R2
    lsb_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (st[k][0] != $past(st[k][0])));
    // R2
    low_pair_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (st[k][1:0] == $past(st[k][1:0]) + INC_L));
  end

  assign b_gt = nx[0] > nx[1];
  assign c_gt = nx[2] > nx[3];

  always_ff @(posedge clk) begin
    if (rst) bit_out <= 1'b0;
    else     bit_out <= b_gt ^ c_gt;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> !bit_out);

endmodule

// File: tb/test_clcg_bitgen.sv
`timescale 1ns/1ps
module test_clcg_bitgen;
  localparam int W = 8;
  localparam int N = 1 << W;
  localparam int BSH [4] = '{2, 3, 4, 5};
  localparam int BINC[4] = '{1, 7, 13, 201};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] seed0 = '0, seed1 = '0, seed2 = '0, seed3 = '0;
  logic bit_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ms [4];
  int exp_bit;
  bit hist [2*N];

  always #4 clk = ~clk;

  clcg_bitgen #(.W(W), .SH0(BSH[0]), .SH1(BSH[1]), .SH2(BSH[2]), .SH3(BSH[3]),
                .INC0(BINC[0]), .INC1(BINC[1]), .INC2(BINC[2]), .INC3(BINC[3]))
    i_clcg_bitgen (.clk(clk), .rst(rst), .seed0(seed0), .seed1(seed1),
                   .seed2(seed2), .seed3(seed3), .bit_out(bit_out));

  function automatic int fnext(int k, int s);
    return (s * ((1 << BSH[k]) + 1) + BINC[k]) % N;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int nx [4];
    if (rst) begin
      ms[0] = int'(seed0); ms[1] = int'(seed1);
      ms[2] = int'(seed2); ms[3] = int'(seed3);
      exp_bit = 0;
    end else begin
      for (int k = 0; k < 4; k++) nx[k] = fnext(k, ms[k]);
      exp_bit = int'(nx[0] > nx[1]) ^ int'(nx[2] > nx[3]);
      for (int k = 0; k < 4; k++) ms[k] = nx[k];
    end
  endtask

  task automatic tick(string req);
    model_edge();
    @(negedge clk);
    check(req, int'(bit_out), exp_bit);
  endtask

  task automatic do_reset(int s0, int s1, int s2, int s3);
    seed0 = W'(s0); seed1 = W'(s1); seed2 = W'(s2); seed3 = W'(s3);
    rst = 1'b1;
    tick("R1 reset output");
    tick("R1 reset output");
    rst = 1'b0;
    tick("R5 first bit after release");
  endtask

  function automatic int seed_for(int k, int target);
    for (int s = 0; s < N; s++) if (fnext(k, s) == target) return s;
    return 0;
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ones;
    int mism;
    @(negedge clk);
    do_reset(8'h3c, 8'ha5, 8'h0f, 8'hd2);
    for (int i = 0; i < 2*N; i++) begin
      tick("R2 R5 stream");
      hist[i] = bit_out;
    end
    mism = 0; ones = 0;
    for (int t = 0; t < N; t++) begin
      if (hist[t] != hist[t+N]) mism++;
      ones += int'(hist[t]);
    end
    check("R6 period repeat mismatches", mism, 0);
    check("R6 sequence not constant", int'(ones > 0 && ones < N), 1);

    do_reset(0, 0, 0, 0);
    for (int i = 0; i < 300; i++) tick("R2 R5 zero seeds");
    do_reset(255, 255, 255, 255);
    for (int i = 0; i < 300; i++) tick("R2 R5 ones seeds");

    // R3 tie: unit 1's next equals unit 0's next, unit 2 > unit 3
    seed0 = 8'd40;
    seed2 = W'(seed_for(2, 200));
    seed3 = W'(seed_for(3, 10));
    seed1 = W'(seed_for(1, fnext(0, 40)));
    rst = 1'b1;
    tick("R1 reset output");
    rst = 1'b0;
    tick("R3 tie gives zero");
    check("R3 tie expected bit", int'(bit_out), 1);

    // R4 tie: unit 3's next equals unit 2's next, unit 0 > unit 1
    seed0 = W'(seed_for(0, 250));
    seed1 = W'(seed_for(1, 3));
    seed2 = 8'd77;
    seed3 = W'(seed_for(3, fnext(2, 77)));
    rst = 1'b1;
    tick("R1 reset output");
    rst = 1'b0;
    tick("R4 tie gives zero");
    check("R4 tie expected bit", int'(bit_out), 1);

    for (int i = 0; i < 100; i++) tick("R2 R5 after ties");
    rst = 1'b1;
    seed0 = 8'h11; seed1 = 8'h22; seed2 = 8'h33; seed3 = 8'h44;
    for (int i = 0; i < 3; i++) tick("R1 mid-run reset");
    rst = 1'b0;
    for (int i = 0; i < 400; i++) tick("R2 R5 reseeded");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule